// File: doc/BRIEF.md
# PWM Capture and Compare DMA Request Generator

This block holds the DMA configuration word of one PWM channel and turns capture and timing events into two request lines for a DMA engine. The read request tells the engine that capture data is ready. Its cause is chosen by a 2-bit source code: FIFO watermark flags, the counter matching compare value 1, or the reload event. The write request asks the engine to refill the compare and fractional-compare registers after each reload.

A read-source state machine has four states. OFF is used when the source code is 0. LEVEL is used when the source code is 1. ARMED is used when the source code is 2 or 3 and nothing is pending. PENDING holds a sticky request.
- ARMED moves to PENDING on the selected event.
- PENDING moves back to ARMED on a read acknowledge.
- Any state moves to OFF or LEVEL when the code changes to 0 or 1.

In LEVEL, the request follows the enabled watermark flags in the same cycle. The flags are combined by OR or by AND.

A write-request state machine has three states. DISABLED is used while the write-request bit is clear. IDLE waits for a reload. PENDING holds the request. IDLE moves to PENDING on a reload. PENDING moves back to IDLE on a write acknowledge.

Top module: `pwm_dma_req_gen`

## Requirements
- R1: After reset the configuration reads 0x0000, and `rd_req` and `wr_req` are low.
- R2: A register write stores bits 9:0, visible on `reg_rd_data` from the next cycle. Bits 15:10 always read zero, whatever is written to them.
- R3: The configuration fields are:
  - bits 5:0: watermark enables;
  - bits 7:6: read source code;
  - bit 8: combine mode;
  - bit 9: write-request enable.
  With source code 0, `rd_req` stays low whatever the watermark flags and events do.
- R4: With source code 1 and bit 8 = 0, `rd_req` is high in the same cycle that any enabled flag is high. Enable bit i gates `fifo_wm[i]`, and bits 0..5 stand for FIFOs X0, X1, B0, B1, A0, A1.
- R5: With source code 1 and bit 8 = 1, `rd_req` is high only while every enabled flag is high. If no enable bit is set, `rd_req` is low in either combine mode.
- R6: With source code 2, a `cmp1_match` pulse makes `rd_req` high from the next cycle. `reload_evt` does not raise it.
- R7: With source code 3, a `reload_evt` pulse makes `rd_req` high from the next cycle. `cmp1_match` does not raise it.
- R8: In source codes 2 and 3, the read request stays high until `rd_ack` clears it on the following cycle. If the selected event and `rd_ack` arrive in the same cycle, the request stays high. `rd_ack` with nothing pending has no effect.
- R9: A pending sticky read request is discarded when the source code is set to 0 or 1. Going back to code 2 or 3 does not bring it back.
- R10: With bit 9 = 1, `reload_evt` makes `wr_req` high from the next cycle, held until `wr_ack`. A reload in the same cycle as `wr_ack` keeps it high. With bit 9 = 0, `wr_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Configuration write strobe |
| reg_wr_data | input | 16 | Configuration write data |
| reg_rd_data | output | 16 | Configuration read data |
| fifo_wm | input | 6 | Capture FIFO watermark flags, X0 at bit 0 through A1 at bit 5 |
| cmp1_match | input | 1 | Pulse: counter equals compare value 1 |
| reload_evt | input | 1 | Pulse: reload flag sets |
| rd_ack | input | 1 | DMA read acknowledge strobe |
| wr_ack | input | 1 | DMA write acknowledge strobe |
| rd_req | output | 1 | DMA read request |
| wr_req | output | 1 | DMA write request |

## Verification
The case that matters is a request being set and cleared in the same cycle. The selected event and its acknowledge are driven together on one clock, once on the read path (reload with `rd_ack` under code 3) and once on the write path (reload with `wr_ack`). The request must still be high on the cycle after, and a lone acknowledge must then drop it. A reload under code 3 with bit 9 set drives both machines from one pulse, and both requests are judged together on the next cycle.

// File: rtl/pwm_dma_pkg.sv
package pwm_dma_pkg;

    parameter int NUM_WM = 6;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_WM     = 2'd1,
        SRC_SYNC   = 2'd2,
        SRC_RELOAD = 2'd3
    } rd_src_e;

    // Packed from MSB: write enable (bit 9) down to watermark enables (bits 5:0)
    typedef struct packed {
        logic              wr_en;
        logic              wm_and;
        rd_src_e           src;
        logic [NUM_WM-1:0] wm_en;
    } dma_cfg_t;

    localparam int CFG_W = $bits(dma_cfg_t);

    typedef enum logic [1:0] {
        RD_OFF   = 2'd0,
        RD_LEVEL = 2'd1,
        RD_ARMED = 2'd2,
        RD_PEND  = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_DISABLED = 2'd0,
        WR_IDLE     = 2'd1,
        WR_PEND     = 2'd2
    } wr_state_e;

endpackage

// File: rtl/pdr_cfg_reg.sv
module pdr_cfg_reg
    import pwm_dma_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output dma_cfg_t         cfg,
    output logic [REG_W-1:0] rd_data
);
    localparam int PAD_W = REG_W - CFG_W;

    dma_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= dma_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    assign cfg = cfg_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, cfg_q};
        end else begin : g_nopad
            assign rd_data = cfg_q;
        end
    endgenerate

    AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:CFG_W] == '0);  // R2

    AST_CFG_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CFG_W-1:0] == $past(wr_data[CFG_W-1:0]));  // R2

endmodule

// File: rtl/pdr_wm_combine.sv
module pdr_wm_combine #(
    parameter int NUM_FLAGS = 6
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] enables,
    input  logic                 and_mode,
    output logic                 hit
);
    logic [NUM_FLAGS-1:0] any_term;
    logic [NUM_FLAGS-1:0] all_term;

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            assign any_term[i] = enables[i] & flags[i];
            assign all_term[i] = ~enables[i] | flags[i];
        end
    endgenerate

    always_comb begin
        if (and_mode) begin
            hit = (|enables) & (&all_term);
        end else begin
            hit = |any_term;
        end
    end

endmodule

// File: rtl/pdr_rd_fsm.sv
module pdr_rd_fsm
    import pwm_dma_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rd_src_e src,
    input  logic    wm_hit,
    input  logic    sync_evt,
    input  logic    reload_evt,
    input  logic    rd_ack,
    output logic    rd_req
);
    rd_state_e st_q, st_d;
    logic      evt_mode;
    logic      evt_hit;

    assign evt_mode = (src == SRC_SYNC) || (src == SRC_RELOAD);
    assign evt_hit  = ((src == SRC_SYNC) && sync_evt) ||
                      ((src == SRC_RELOAD) && reload_evt);

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_NONE: st_d = RD_OFF;
            SRC_WM:   st_d = RD_LEVEL;
            default: begin
                if (evt_hit) begin
                    st_d = RD_PEND;
                end else if (st_q == RD_PEND && !rd_ack) begin
                    st_d = RD_PEND;
                end else begin
                    st_d = RD_ARMED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RD_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_req = 1'b0;
        unique case (st_q)
            RD_OFF:   rd_req = 1'b0;
            RD_LEVEL: rd_req = 1'b0;
            RD_ARMED: rd_req = 1'b0;
            RD_PEND:  rd_req = evt_mode;
        endcase
        if (src == SRC_WM) begin
            rd_req = wm_hit;
        end
    end

    AST_RD_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit |=> st_q == RD_PEND);  // R6

    AST_RD_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RD_PEND && evt_mode && !rd_ack) |=> st_q == RD_PEND);  // R8

    AST_RD_NONEVT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_mode |=> st_q != RD_PEND);  // R9

    AST_RD_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |-> !rd_req);  // R3

endmodule

// File: rtl/pdr_wr_fsm.sv
module pdr_wr_fsm
    import pwm_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic reload_evt,
    input  logic wr_ack,
    output logic wr_req
);
    wr_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = WR_DISABLED;
        end else begin
            unique case (st_q)
                WR_DISABLED, WR_IDLE: st_d = reload_evt ? WR_PEND : WR_IDLE;
                WR_PEND:              st_d = (reload_evt || !wr_ack) ? WR_PEND : WR_IDLE;
                default:              st_d = WR_DISABLED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WR_DISABLED;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        wr_req = 1'b0;
        unique case (st_q)
            WR_PEND: wr_req = enable;
            default: wr_req = 1'b0;
        endcase
    end

    AST_WR_RELOAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && reload_evt) |=> st_q == WR_PEND);  // R10

    AST_WR_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WR_PEND && enable && !wr_ack) |=> st_q == WR_PEND);  // R10

    AST_WR_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> st_q == WR_DISABLED);  // R10

endmodule

// File: rtl/pwm_dma_req_gen.sv
module pwm_dma_req_gen
    import pwm_dma_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic [NUM_WM-1:0] fifo_wm,
    input  logic             cmp1_match,
    input  logic             reload_evt,
    input  logic             rd_ack,
    input  logic             wr_ack,
    output logic             rd_req,
    output logic             wr_req
);
    dma_cfg_t cfg;
    logic     wm_hit;

    pdr_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .cfg     (cfg),
        .rd_data (reg_rd_data)
    );

    pdr_wm_combine #(.NUM_FLAGS(NUM_WM)) u_comb (
        .flags    (fifo_wm),
        .enables  (cfg.wm_en),
        .and_mode (cfg.wm_and),
        .hit      (wm_hit)
    );

    pdr_rd_fsm u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (cfg.src),
        .wm_hit     (wm_hit),
        .sync_evt   (cmp1_match),
        .reload_evt (reload_evt),
        .rd_ack     (rd_ack),
        .rd_req     (rd_req)
    );

    pdr_wr_fsm u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg.wr_en),
        .reload_evt (reload_evt),
        .wr_ack     (wr_ack),
        .wr_req     (wr_req)
    );

    AST_TOP_NO_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_WM && cfg.wm_en == '0) |-> !rd_req);  // R5

endmodule

// File: tb/sim_pwm_dma_req_gen.sv
module sim_pwm_dma_req_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic [15:0] reg_rd_data;
    logic [5:0]  fifo_wm = '0;
    logic        cmp1_match = 1'b0;
    logic        reload_evt = 1'b0;
    logic        rd_ack = 1'b0;
    logic        wr_ack = 1'b0;
    logic        rd_req;
    logic        wr_req;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dma_req_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .fifo_wm(fifo_wm), .cmp1_match(cmp1_match),
        .reload_evt(reload_evt), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .rd_req(rd_req), .wr_req(wr_req)
    );

    // {combine mode, source code, enables, flags, expected rd_req}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 2'd1, 6'b000001, 6'b000001, 1'b1},  // R4 X0 alone
        {1'b0, 2'd1, 6'b000011, 6'b000010, 1'b1},  // R4 X1 via OR
        {1'b1, 2'd1, 6'b000011, 6'b000010, 1'b0},  // R5 partial AND
        {1'b1, 2'd1, 6'b000011, 6'b000011, 1'b1},  // R5 full AND
        {1'b0, 2'd1, 6'b000000, 6'b111111, 1'b0},  // R5 no enables OR
        {1'b1, 2'd1, 6'b000000, 6'b111111, 1'b0},  // R5 no enables AND
        {1'b1, 2'd1, 6'b110000, 6'b110000, 1'b1},  // R5 A0/A1 AND
        {1'b1, 2'd1, 6'b110000, 6'b001111, 1'b0},  // R5 disabled flags only
        {1'b0, 2'd1, 6'b101010, 6'b010101, 1'b0},  // R4 disjoint OR
        {1'b0, 2'd0, 6'b111111, 6'b111111, 1'b0}   // R3 source off
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic cyc(input logic cm, input logic rl, input logic ra, input logic wa);
        cmp1_match = cm; reload_evt = rl; rd_ack = ra; wr_ack = wa;
        @(negedge clk);
        cmp1_match = 1'b0; reload_evt = 1'b0; rd_ack = 1'b0; wr_ack = 1'b0;
    endtask

    function automatic logic [15:0] cfgv(input logic we, input logic am,
                                         input logic [1:0] s, input logic [5:0] en);
        return {6'b0, we, am, s, en};
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cfg", reg_rd_data, 16'h0000);
        chk("R1 rd_req", {15'b0, rd_req}, 16'h0);
        chk("R1 wr_req", {15'b0, wr_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback with upper bits dropped
        wr_cfg(16'hFFFF);
        chk("R2 readback", reg_rd_data, 16'h03FF);
        wr_cfg(16'h0000);

        // watermark table
        for (int i = 0; i < NVEC; i++) begin
            wr_cfg(cfgv(1'b0, VEC[i][15], VEC[i][14:13], VEC[i][12:7]));
            fifo_wm = VEC[i][6:1];
            #1;
            chk("R3/R4/R5 vector", {15'b0, rd_req}, {15'b0, VEC[i][0]});
            fifo_wm = '0;
        end

        // R3 events ignored under code 0
        wr_cfg(cfgv(1'b0, 1'b0, 2'd0, 6'b0));
        cyc(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 events ignored", {15'b0, rd_req}, 16'h0);

        // R6 sync source
        wr_cfg(cfgv(1'b0, 1'b0, 2'd2, 6'b0));
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R6 reload ignored", {15'b0, rd_req}, 16'h0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R6 sync sets", {15'b0, rd_req}, 16'h1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 held", {15'b0, rd_req}, 16'h1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 ack clears", {15'b0, rd_req}, 16'h0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 idle ack", {15'b0, rd_req}, 16'h0);

        // R7 reload source, plus same-cycle set and ack
        wr_cfg(cfgv(1'b0, 1'b0, 2'd3, 6'b0));
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 sync ignored", {15'b0, rd_req}, 16'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 reload sets", {15'b0, rd_req}, 16'h1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R8 event wins over ack", {15'b0, rd_req}, 16'h1);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 ack clears", {15'b0, rd_req}, 16'h0);

        // R9 sticky discarded on code 0 and on code 1
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        wr_cfg(cfgv(1'b0, 1'b0, 2'd0, 6'b0));
        chk("R9 code0 hides", {15'b0, rd_req}, 16'h0);
        wr_cfg(cfgv(1'b0, 1'b0, 2'd3, 6'b0));
        chk("R9 not restored", {15'b0, rd_req}, 16'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        wr_cfg(cfgv(1'b0, 1'b0, 2'd1, 6'b0));
        chk("R9 code1 hides", {15'b0, rd_req}, 16'h0);
        wr_cfg(cfgv(1'b0, 1'b0, 2'd2, 6'b0));
        chk("R9 not restored code1", {15'b0, rd_req}, 16'h0);

        // R10 write requests
        wr_cfg(cfgv(1'b0, 1'b0, 2'd0, 6'b0));
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 disabled", {15'b0, wr_req}, 16'h0);
        wr_cfg(cfgv(1'b1, 1'b0, 2'd3, 6'b0));
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R10 reload sets", {15'b0, wr_req}, 16'h1);
        chk("R7 shared reload", {15'b0, rd_req}, 16'h1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 held", {15'b0, wr_req}, 16'h1);
        cyc(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R10 reload wins over ack", {15'b0, wr_req}, 16'h1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 ack clears", {15'b0, wr_req}, 16'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        wr_cfg(cfgv(1'b0, 1'b0, 2'd0, 6'b0));
        chk("R10 gate drops", {15'b0, wr_req}, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule